// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between four external interrupt request pins and a prioritizing interrupt controller. Each pin is first brought into the clock domain by a synchronizer. It is then qualified by a per-line polarity setting and handled in one of two ways. A level-sensitive line passes its qualified state straight through, so the request lasts only while the external source holds its active level. An edge-triggered line latches a pending bit on the selected transition, and that bit stays set until software clears it.

Software reaches the block through a small register bus with two locations: a 16-bit configuration register and a status register. The block drives a pending vector with one bit per line, plus a single combined request. Priority, masking and vectoring belong to the downstream controller.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the configuration register reads 0x0000, every pending bit is 0 and the combined request is 0. Every line therefore starts level-sensitive with active-low polarity, and the synchronizers reset to the idle-high state.
- R2: Address 0 selects the configuration register. For line i (i = 0..3), the polarity bit sits at position 15-i and the edge-select bit at position 11-i. Bits 7:0 read back as written and drive no logic. Rewriting a line with the same polarity and edge-select leaves its pending bit untouched.
- R3: A line with edge-select 0 is level-sensitive. Its pending bit is 1 exactly while the synchronized input equals its polarity bit, so polarity 1 means high-active. A change at the pin shows on the pending output at the third rising clock edge after it.
- R4: A line with edge-select 1 sets its pending bit on a transition into the active level. That is a low-to-high transition with polarity 1, or a high-to-low transition with polarity 0. The bit appears at the third rising edge after the pin changes.
- R5: Address 1 selects the status register. It reads the pending vector in bits 3:0 and zero above. In edge mode a pending bit stays set, whatever the pin does, until a write to address 1 carries a 1 in that line's bit position. The bit is then 0 right after that write's clock edge.
- R6: If a clear write and a new qualifying edge act on the same line in the same cycle, the pending bit stays set.
- R7: Writing 1 to a status bit of a level-sensitive line has no effect on its pending bit.
- R8: Any change to a line's polarity or edge-select clears that line's pending bit and its edge history. The reconfiguration itself never produces an edge, so a line that is inactive under its new settings stays clear until a genuine transition arrives.
- R9: The combined request is registered and always equals the OR of the pending bits, changing on the same clock edge as they do.
- R10: In edge mode a transition away from the active level, or a steady input, never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 4 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | 1 | Register select: 0 configuration, 1 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| irq_pending | output | 4 | Per-line pending vector |
| irq_req | output | 1 | Combined interrupt request |

## Verification
Four properties are checked on every cycle:
- A level line's pending bit tracks its qualified synchronized input.
- An edge line's pending bit holds unless a clear arrives.
- An edge line's pending bit can only rise when the qualified input is active.
- The combined request equals the OR of the pending bits, and a reconfiguration always empties the pending bit.

Several behaviours appear only in the bench scenarios:
- The three-edge pin-to-output latency.
- The absence of any false edge after a polarity flip.
- A new edge winning over a simultaneous clear.
- Unused configuration bits reading back without effect.

These are observed at the ports against a cycle model, with random pin activity and register writes mixed in.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
   typedef enum logic {
      REG_CTRL = 1'b0,
      REG_STAT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int          N       = 4,
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [N-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) st[k] <= {N{RST_VAL}};
      end else begin
         st[0] <= d;
         for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_sense_pkg::*;
#(
   parameter int N_LINES = 4,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  reg_sel_e           sel,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [N_LINES-1:0] pend,
   output logic [DATA_W-1:0]  rdata,
   output logic [N_LINES-1:0] pol,
   output logic [N_LINES-1:0] et,
   output logic [N_LINES-1:0] chg,
   output logic [N_LINES-1:0] clr
);
   localparam int POL_TOP = DATA_W - 1;
   localparam int ET_TOP  = DATA_W - 1 - N_LINES;

   logic [DATA_W-1:0] ctrl_q;
   logic              wr_ctrl, wr_stat;

   assign wr_ctrl = wr && (sel == REG_CTRL);
   assign wr_stat = wr && (sel == REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wdata;
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_field
      assign pol[i] = ctrl_q[POL_TOP-i];
      assign et[i]  = ctrl_q[ET_TOP-i];
      assign chg[i] = wr_ctrl && ((wdata[POL_TOP-i] != ctrl_q[POL_TOP-i]) ||
                                  (wdata[ET_TOP-i]  != ctrl_q[ET_TOP-i]));
      assign clr[i] = wr_stat && wdata[i];
   end

   assign rdata = (sel == REG_STAT) ? DATA_W'(pend) : ctrl_q;
endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   input  logic pol,
   input  logic et,
   input  logic chg,
   input  logic clr,
   output logic pend,
   output logic pend_d
);
   logic q, qh, qh_d;

   assign q = (s == pol);

   always_comb begin
      if (chg) begin
         pend_d = 1'b0;
         qh_d   = 1'b1;
      end else begin
         qh_d   = q;
         pend_d = et ? ((q & ~qh) | (pend & ~clr)) : q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         qh   <= 1'b1;
      end else begin
         pend <= pend_d;
         qh   <= qh_d;
      end
   end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import irq_sense_pkg::*;
#(
   parameter int N_LINES     = 4,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_in,
   input  logic               bus_wr,
   input  logic               bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [N_LINES-1:0] irq_pending,
   output logic               irq_req
);
   if (2 * N_LINES > DATA_W) begin : g_bad_width
      $error("ext_irq_sense: DATA_W too narrow for the per-line fields");
   end
   if (N_LINES < 1) begin : g_bad_lines
      $error("ext_irq_sense: N_LINES must be at least 1");
   end

   logic [N_LINES-1:0] sync_q, cfg_pol, cfg_et, cfg_chg, clr_hit, pend_d;

   irq_sync #(.N(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_q)
   );

   irq_cfg_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(reg_sel_e'(bus_addr)),
      .wdata(bus_wdata), .pend(irq_pending), .rdata(bus_rdata),
      .pol(cfg_pol), .et(cfg_et), .chg(cfg_chg), .clr(clr_hit)
   );

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      irq_line_sense u_line (
         .clk(clk), .rst_n(rst_n), .s(sync_q[i]), .pol(cfg_pol[i]),
         .et(cfg_et[i]), .chg(cfg_chg[i]), .clr(clr_hit[i]),
         .pend(irq_pending[i]), .pend_d(pend_d[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_req <= 1'b0;
      else        irq_req <= |pend_d;
   end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
   parameter int N_LINES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_LINES-1:0] sync_q,
   input logic [N_LINES-1:0] pol,
   input logic [N_LINES-1:0] et,
   input logic [N_LINES-1:0] chg,
   input logic [N_LINES-1:0] clr,
   input logic [N_LINES-1:0] pend,
   input logic               req
);
   AST_REQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
      req == (|pend)); // R9

   for (genvar i = 0; i < N_LINES; i++) begin : g_ln
      AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
         (!et[i] && !chg[i]) |=> (pend[i] == $past(sync_q[i] ~^ pol[i]))); // R3

      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (et[i] && pend[i] && !clr[i] && !chg[i]) |=> pend[i]); // R5

      AST_EDGE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (et[i] && !pend[i] && !chg[i]) |=> (!pend[i] || $past(sync_q[i] ~^ pol[i]))); // R10

      AST_RECFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         chg[i] |=> !pend[i]); // R8
   end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.N_LINES(N_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .pol(cfg_pol), .et(cfg_et),
   .chg(cfg_chg), .clr(clr_hit), .pend(irq_pending), .req(irq_req)
);

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  irq_in;
   logic        bus_wr, bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic [3:0]  irq_pending;
   logic        irq_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   ext_irq_sense u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pending(irq_pending), .irq_req(irq_req)
   );

   // cycle model built from the requirements
   logic [3:0]  m_s1, m_s2, m_pend, m_qh, n_pend, n_qh;
   logic [15:0] m_ctrl;
   logic        m_q, m_chg, m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= 4'hF; m_s2 <= 4'hF; m_pend <= '0; m_qh <= 4'hF; m_ctrl <= '0;
      end else begin
         for (int i = 0; i < 4; i++) begin
            m_q   = (m_s2[i] == m_ctrl[15-i]);
            m_chg = bus_wr && !bus_addr &&
                    ({bus_wdata[15-i], bus_wdata[11-i]} != {m_ctrl[15-i], m_ctrl[11-i]});
            m_clr = bus_wr && bus_addr && bus_wdata[i];
            if (m_chg) begin
               n_pend[i] = 1'b0; n_qh[i] = 1'b1;
            end else if (!m_ctrl[11-i]) begin
               n_pend[i] = m_q; n_qh[i] = m_q;
            end else begin
               n_pend[i] = (m_q & ~m_qh[i]) | (m_pend[i] & ~m_clr);
               n_qh[i]   = m_q;
            end
         end
         m_pend <= n_pend;
         m_qh   <= n_qh;
         m_s1   <= irq_in;
         m_s2   <= m_s1;
         if (bus_wr && !bus_addr) m_ctrl <= bus_wdata;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         chk("R3 R4 R5 pending vs model", {12'h0, irq_pending}, {12'h0, m_pend});
         chk("R9 combined request", {15'h0, irq_req}, {15'h0, |m_pend});
         chk("R2 R5 read data", bus_rdata, bus_addr ? {12'h0, m_pend} : m_ctrl);
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; irq_in = 4'hF; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      chk("R1 config after reset", bus_rdata, 16'h0000);
      chk("R1 pending after reset", {12'h0, irq_pending}, 16'h0);
      chk("R1 request after reset", {15'h0, irq_req}, 16'h0);

      // level line 0, active low
      irq_in[0] = 1'b0;
      cyc(); cyc();
      chk("R3 not yet visible", {12'h0, irq_pending}, 16'h0);
      cyc();
      chk("R3 level asserted", {12'h0, irq_pending}, 16'h1);
      chk("R9 request follows", {15'h0, irq_req}, 16'h1);
      wr(1'b1, 16'h000F);
      chk("R7 clear ignored in level mode", {12'h0, irq_pending}, 16'h1);
      irq_in[0] = 1'b1;
      repeat (3) cyc();
      chk("R3 level released", {12'h0, irq_pending}, 16'h0);

      // line 1 edge, rising; unused bits set
      bus_addr = 1'b0;
      wr(1'b0, 16'h44A5);
      chk("R2 config readback", bus_rdata, 16'h44A5);
      repeat (4) cyc();
      chk("R8 no false edge after switch", {12'h0, irq_pending}, 16'h0);
      irq_in[1] = 1'b0;
      repeat (4) cyc();
      chk("R10 falling ignored with rising polarity", {12'h0, irq_pending}, 16'h0);
      irq_in[1] = 1'b1;
      cyc(); cyc();
      chk("R4 edge not yet visible", {12'h0, irq_pending}, 16'h0);
      cyc();
      chk("R4 rising edge latched", {12'h0, irq_pending}, 16'h2);
      irq_in[1] = 1'b0;
      repeat (4) cyc();
      chk("R5 sticky after pin drops", {12'h0, irq_pending}, 16'h2);
      bus_addr = 1'b1;
      #0;
      chk("R5 status read", bus_rdata, 16'h0002);
      wr(1'b1, 16'h0002);
      chk("R5 write-one clears", {12'h0, irq_pending}, 16'h0);

      // clear collides with a new edge
      irq_in[1] = 1'b1;
      repeat (3) cyc();
      irq_in[1] = 1'b0;
      repeat (3) cyc();
      chk("R5 held before collision", {12'h0, irq_pending}, 16'h2);
      irq_in[1] = 1'b1;
      cyc(); cyc();
      wr(1'b1, 16'h0002);
      chk("R6 new edge beats clear", {12'h0, irq_pending}, 16'h2);

      // polarity flip on a pending line
      wr(1'b0, 16'h04A5);
      chk("R8 reconfig clears pending", {12'h0, irq_pending}, 16'h0);
      repeat (4) cyc();
      chk("R8 no edge from polarity flip", {12'h0, irq_pending}, 16'h0);
      irq_in[1] = 1'b0;
      repeat (3) cyc();
      chk("R4 falling edge latched", {12'h0, irq_pending}, 16'h2);
      wr(1'b0, 16'h04FF);
      repeat (2) cyc();
      chk("R2 unused bits leave pending alone", {12'h0, irq_pending}, 16'h2);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         for (int b = 0; b < 4; b++)
            if ($urandom_range(7) == 0) irq_in[b] = ~irq_in[b];
         bus_addr  = 1'($urandom_range(1));
         bus_wr    = ($urandom_range(11) == 0);
         bus_wdata = 16'($urandom);
         cyc();
      end
      bus_wr = 1'b0;
      cyc();
      finish_run();
   end
endmodule